// File: doc/BRIEF.md
# Serially Programmed Clock Fan-Out Enable Controller

This block is the control side of a one-in, many-out clock distribution buffer. One reference clock drives twelve output pairs, each with a true leg and a second leg, plus one feedback output. A two-wire SMBus slave, sampled by a fast system clock, receives block writes and keeps a set of enable bits. Each enable bit gates one output pair, or the feedback output, so that an unused output can be stopped.

A mode input selects how the second leg of the first six pairs behaves. In one setting it is the inverse of the reference. In the other it is a second true copy. The upper six pairs always give a true and an inverted leg. An active-low power-down input holds every clock output low, whatever the enable bits say.

The SCL and SDA lines each pass through a two-flop synchronizer and then a filter that needs three equal samples before it accepts a new level. Start, stop and clock-edge detection all work on these filtered lines. Data bytes land at consecutive indices. Only indices 6 and 7 hold enable bits.

Top module: `fanout_enable_ctrl`

## Requirements
- R1: After reset every enable bit is 1, so every pair and the feedback output follow the reference, and the SDA pull-down is released.
- R2: A transfer is acknowledged only when the address byte carries 7-bit address 1101001 (0x69) and a write bit of 0. Any other address, or a read bit of 1, gets no acknowledge and changes no output.
- R3: After the address, the slave takes a command byte, then a count byte, then data bytes at indices 0, 1, 2 and so on, all shifted in MSB first. Every one of these bytes is acknowledged. Only data indices 6 and 7 affect the outputs.
- R4: At data index 6, bit 4 enables the feedback output and bits 3..0 enable pairs 11..8. Bits 7..5 have no effect.
- R5: At data index 7, bit n enables pair n, for n from 7 down to 0.
- R6: An enable bit of 0 holds both legs of its pair low, or holds the feedback output low. An enable bit of 1 lets them toggle.
- R7: While the power-down input is 0, every true leg, every second leg and the feedback output are 0.
- R8: With the mode input at 1, pairs 0..5 drive the reference on the true leg and its inverse on the second leg. With the mode input at 0, both legs of pairs 0..5 drive the reference.
- R9: Pairs 6..11 always drive the reference on the true leg and its inverse on the second leg, whatever the mode input.
- R10: A stop condition or a repeated start ends the transfer. Bytes that completed before it stay in effect. A byte cut off part way through has no effect.
- R11: A pulse on SCL that lasts fewer than three system clock samples is ignored by the receiver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Reference clock to be fanned out |
| mode_inv | input | 1 | 1: pairs 0..5 have an inverted second leg; 0: both legs are true |
| pwrdn_n | input | 1 | Active-low power-down; 0 forces all clock outputs low |
| scl_in | input | 1 | Serial clock line |
| sda_in | input | 1 | Serial data line, as seen on the wire |
| sda_oe | output | 1 | 1 pulls the SDA line low (acknowledge) |
| out_t | output | 12 | True legs of pairs 11..0 |
| out_c | output | 12 | Second legs of pairs 11..0 |
| fb_out | output | 1 | Feedback clock output |

## Verification
A level change on a serial pin reaches the filtered line six system cycles later. The receiver sees it one cycle after that. A completed enable byte reaches the registers on the next cycle. The clock outputs are combinational from the reference, the mode, the power-down input and the enable registers, so the gating tracks those with no clock latency. The bench gives every serial phase ten system cycles, which is longer than the eight-cycle path above. It samples the acknowledge halfway through the ninth SCL high phase and waits twenty cycles after each stop before it looks at the outputs. Each output check changes the reference or the mode just after a falling system edge and samples 1 ns later, once with the reference low and once with it high.

// File: rtl/fec_pkg.sv
package fec_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_ADDR,
    RX_DATA,
    RX_ACKWAIT,
    RX_ACK
  } rx_state_t;

  // byte sequence after the address: command, count, then data index 0..
  localparam int DATA_BASE  = 2;
  localparam int REG_IDX_HI = 6;
  localparam int REG_IDX_LO = 7;
  localparam int LO_PAIRS   = 8;
endpackage

// File: rtl/fec_line_filter.sv
module fec_line_filter #(
  parameter int   SYNC_STAGES = 2,
  parameter int   FILT_LEN    = 3,
  parameter logic INIT        = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= {SYNC_STAGES{INIT}};
      hist_q <= {FILT_LEN{INIT}};
      dout   <= INIT;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&hist_q)
        dout <= 1'b1;
      else if (~|hist_q)
        dout <= 1'b0;
    end
  end
endmodule

// File: rtl/fec_smbus_rx.sv
module fec_smbus_rx
  import fec_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter int         IDX_W      = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      scl_f,
  input  logic      sda_f,
  output logic      sda_oe,
  output logic      wr_hi,
  output logic      wr_lo,
  output logic [7:0] wr_data,
  output rx_state_t rx_st,
  output logic      stop_evt
);
  localparam logic [IDX_W-1:0] SEQ_HI  = IDX_W'(DATA_BASE + REG_IDX_HI);
  localparam logic [IDX_W-1:0] SEQ_LO  = IDX_W'(DATA_BASE + REG_IDX_LO);
  localparam logic [IDX_W-1:0] SEQ_MAX = '1;

  logic             scl_d, sda_d;
  logic [6:0]       sh_q;
  logic [2:0]       bit_q;
  logic [IDX_W-1:0] seq_q;
  logic             start_c, rise_c, fall_c;
  logic [7:0]       byte_c;

  assign start_c  = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_evt = scl_f & scl_d & ~sda_d & sda_f;
  assign rise_c   = scl_f & ~scl_d;
  assign fall_c   = ~scl_f & scl_d;
  assign byte_c   = {sh_q, sda_f};

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_st   <= RX_IDLE;
      scl_d   <= 1'b1;
      sda_d   <= 1'b1;
      sh_q    <= '0;
      bit_q   <= '0;
      seq_q   <= '0;
      sda_oe  <= 1'b0;
      wr_hi   <= 1'b0;
      wr_lo   <= 1'b0;
      wr_data <= '0;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
      wr_hi <= 1'b0;
      wr_lo <= 1'b0;
      if (start_c) begin
        rx_st  <= RX_ADDR;
        bit_q  <= '0;
        seq_q  <= '0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        rx_st  <= RX_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (rx_st)
          RX_ADDR, RX_DATA: if (rise_c) begin
            sh_q  <= byte_c[6:0];
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              if (rx_st == RX_ADDR) begin
                rx_st <= (byte_c[7:1] == SLAVE_ADDR && !byte_c[0]) ? RX_ACKWAIT : RX_IDLE;
              end else begin
                rx_st   <= RX_ACKWAIT;
                wr_data <= byte_c;
                wr_hi   <= (seq_q == SEQ_HI);
                wr_lo   <= (seq_q == SEQ_LO);
                if (seq_q != SEQ_MAX) seq_q <= seq_q + 1'b1;
              end
            end
          end
          RX_ACKWAIT: if (fall_c) begin
            rx_st  <= RX_ACK;
            sda_oe <= 1'b1;
          end
          RX_ACK: if (fall_c) begin
            rx_st  <= RX_DATA;
            sda_oe <= 1'b0;
            bit_q  <= '0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/fec_enable_regs.sv
module fec_enable_regs
  import fec_pkg::*;
#(
  parameter int HI_PAIRS = 4,
  localparam int NPAIRS  = LO_PAIRS + HI_PAIRS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [7:0]        wr_data,
  output logic [NPAIRS-1:0] en_pairs,
  output logic              fb_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_pairs <= '1;
      fb_en    <= 1'b1;
    end else begin
      if (wr_hi) begin
        fb_en                        <= wr_data[HI_PAIRS];
        en_pairs[NPAIRS-1:LO_PAIRS]  <= wr_data[HI_PAIRS-1:0];
      end
      if (wr_lo)
        en_pairs[LO_PAIRS-1:0] <= wr_data[LO_PAIRS-1:0];
    end
  end
endmodule

// File: rtl/fec_out_gate.sv
module fec_out_gate #(
  parameter int NPAIRS = 12,
  parameter int NSEL   = 6
) (
  input  logic              ref_clk,
  input  logic              mode_inv,
  input  logic              pwrdn_n,
  input  logic [NPAIRS-1:0] en_pairs,
  input  logic              fb_en,
  output logic [NPAIRS-1:0] out_t,
  output logic [NPAIRS-1:0] out_c,
  output logic              fb_out
);
  for (genvar i = 0; i < NPAIRS; i++) begin : g_pair
    logic run;
    assign run      = pwrdn_n & en_pairs[i];
    assign out_t[i] = run & ref_clk;
    if (i < NSEL) begin : g_sel
      assign out_c[i] = run & (mode_inv ? ~ref_clk : ref_clk);
    end else begin : g_inv
      assign out_c[i] = run & ~ref_clk;
    end
  end
  assign fb_out = pwrdn_n & fb_en & ref_clk;
endmodule

// File: rtl/fanout_enable_ctrl.sv
module fanout_enable_ctrl
  import fec_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h69,
  parameter int         HI_PAIRS    = 4,
  parameter int         NSEL_PAIRS  = 6,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  parameter int         IDX_W       = 4,
  localparam int        NPAIRS      = LO_PAIRS + HI_PAIRS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_clk,
  input  logic              mode_inv,
  input  logic              pwrdn_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [NPAIRS-1:0] out_t,
  output logic [NPAIRS-1:0] out_c,
  output logic              fb_out
);
  logic              scl_f, sda_f;
  logic              wr_hi, wr_lo, stop_evt;
  logic [7:0]        wr_data;
  logic [NPAIRS-1:0] en_pairs;
  logic              fb_en;
  rx_state_t         rx_st;

  fec_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN), .INIT(1'b1)) u_scl_filt (
    .clk(clk), .rst(rst), .din(scl_in), .dout(scl_f));

  fec_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN), .INIT(1'b1)) u_sda_filt (
    .clk(clk), .rst(rst), .din(sda_in), .dout(sda_f));

  fec_smbus_rx #(.SLAVE_ADDR(SLAVE_ADDR), .IDX_W(IDX_W)) u_rx (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f), .sda_oe(sda_oe),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data), .rx_st(rx_st), .stop_evt(stop_evt));

  fec_enable_regs #(.HI_PAIRS(HI_PAIRS)) u_regs (
    .clk(clk), .rst(rst), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .en_pairs(en_pairs), .fb_en(fb_en));

  fec_out_gate #(.NPAIRS(NPAIRS), .NSEL(NSEL_PAIRS)) u_gate (
    .ref_clk(ref_clk), .mode_inv(mode_inv), .pwrdn_n(pwrdn_n), .en_pairs(en_pairs),
    .fb_en(fb_en), .out_t(out_t), .out_c(out_c), .fb_out(fb_out));
endmodule

// File: rtl/fanout_enable_ctrl_chk.sv
module fanout_enable_ctrl_chk
  import fec_pkg::*;
#(
  parameter int NPAIRS = 12,
  parameter int NSEL   = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              pwrdn_n,
  input logic              mode_inv,
  input logic              scl_f,
  input logic              sda_oe,
  input logic              stop_evt,
  input rx_state_t         rx_st,
  input logic [NPAIRS-1:0] en_pairs,
  input logic              fb_en,
  input logic [NPAIRS-1:0] out_t,
  input logic [NPAIRS-1:0] out_c,
  input logic              fb_out
);
  localparam logic [NPAIRS-1:0] LOWM = {{(NPAIRS-NSEL){1'b0}}, {NSEL{1'b1}}};

  p_reset_defaults_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (&en_pairs) && fb_en && !sda_oe);

  p_ack_scl_low_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_f);

  p_disabled_low_r6: assert property (@(posedge clk) disable iff (rst)
    ((out_t | out_c) & ~en_pairs) == '0 && (fb_en || !fb_out));

  p_power_down_r7: assert property (@(posedge clk) disable iff (rst)
    !pwrdn_n |-> out_t == '0 && out_c == '0 && !fb_out);

  p_mode_pairs_r8: assert property (@(posedge clk) disable iff (rst)
    pwrdn_n |-> ((out_t ^ out_c) & en_pairs & LOWM) == (mode_inv ? (en_pairs & LOWM) : '0));

  p_upper_pairs_r9: assert property (@(posedge clk) disable iff (rst)
    pwrdn_n |-> ((out_t ^ out_c) & en_pairs & ~LOWM) == (en_pairs & ~LOWM));

  p_stop_ends_r10: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> rx_st == RX_IDLE && !sda_oe);
endmodule

bind fanout_enable_ctrl fanout_enable_ctrl_chk #(.NPAIRS(NPAIRS), .NSEL(NSEL_PAIRS)) u_chk (
  .clk(clk), .rst(rst), .pwrdn_n(pwrdn_n), .mode_inv(mode_inv), .scl_f(scl_f),
  .sda_oe(sda_oe), .stop_evt(stop_evt), .rx_st(rx_st), .en_pairs(en_pairs),
  .fb_en(fb_en), .out_t(out_t), .out_c(out_c), .fb_out(fb_out));

// File: tb/fanout_enable_ctrl_test.sv
`timescale 1ns/1ps
module fanout_enable_ctrl_test;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_clk = 1'b0;
  logic        mode_inv = 1'b1;
  logic        pwrdn_n = 1'b1;
  logic        scl_drv = 1'b1;
  logic        sda_drv = 1'b1;
  logic        sda_oe;
  logic [11:0] out_t, out_c;
  logic        fb_out;
  logic        sda_line;

  assign sda_line = sda_drv & ~sda_oe;

  always #2 clk = ~clk;

  fanout_enable_ctrl uut (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .mode_inv(mode_inv), .pwrdn_n(pwrdn_n),
    .scl_in(scl_drv), .sda_in(sda_line), .sda_oe(sda_oe),
    .out_t(out_t), .out_c(out_c), .fb_out(fb_out));

  int          checks = 0;
  int          errors = 0;
  bit          done = 0;
  logic [11:0] m_en = '1;
  logic        m_fb = 1'b1;
  logic [7:0]  dbuf [16];

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [24:0] exp_out(logic r, logic md, logic pd, logic [11:0] en, logic fb);
    logic [11:0] t, c;
    for (int i = 0; i < 12; i++) begin
      t[i] = pd & en[i] & r;
      if (i < 6 && !md) c[i] = t[i];
      else c[i] = pd & en[i] & ~r;
    end
    return {pd & fb & r, c, t};
  endfunction

  function automatic void apply_byte(int idx, logic [7:0] b);
    if (idx == 6) begin
      m_fb = b[4];
      m_en[11:8] = b[3:0];
    end else if (idx == 7) begin
      m_en[7:0] = b;
    end
  endfunction

  task automatic check_outputs(input string tag);
    for (int r = 0; r < 2; r++) begin
      @(negedge clk);
      ref_clk = r[0];
      #1;
      check(tag, {7'd0, fb_out, out_c, out_t},
            {7'd0, exp_out(r[0], mode_inv, pwrdn_n, m_en, m_fb)});
    end
  endtask

  task automatic bus_start;
    sda_drv = 1'b1; wait_cyc(Q);
    scl_drv = 1'b1; wait_cyc(Q);
    sda_drv = 1'b0; wait_cyc(Q);
    scl_drv = 1'b0; wait_cyc(Q);
  endtask

  task automatic bus_stop;
    sda_drv = 1'b0; wait_cyc(Q);
    scl_drv = 1'b1; wait_cyc(Q);
    sda_drv = 1'b1; wait_cyc(2*Q);
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    sda_drv = b;
    if (glitch) begin
      wait_cyc(2);
      scl_drv = 1'b1; wait_cyc(2);
      scl_drv = 1'b0; wait_cyc(Q);
    end else begin
      wait_cyc(Q);
    end
    scl_drv = 1'b1; wait_cyc(Q);
    scl_drv = 1'b0; wait_cyc(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int glitch_bit, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i], i == glitch_bit);
    sda_drv = 1'b1; wait_cyc(Q);
    scl_drv = 1'b1; wait_cyc(Q/2);
    ack = ~sda_line;
    wait_cyc(Q/2);
    scl_drv = 1'b0; wait_cyc(Q);
  endtask

  // full block write: address, command, count, ndata bytes from dbuf
  task automatic block_write(input logic [6:0] a, input logic rw, input int ndata,
                             input logic exp_ack, input string tag);
    logic ack;
    bus_start();
    send_byte({a, rw}, -1, ack);
    check({tag, " R2 address ack"}, {31'd0, ack}, {31'd0, exp_ack});
    if (exp_ack) begin
      send_byte(8'h00, -1, ack);
      check({tag, " R3 command ack"}, {31'd0, ack}, 32'd1);
      send_byte(8'(ndata), -1, ack);
      check({tag, " R3 count ack"}, {31'd0, ack}, 32'd1);
      for (int i = 0; i < ndata; i++) begin
        send_byte(dbuf[i], -1, ack);
        check({tag, " R3 data ack"}, {31'd0, ack}, 32'd1);
        apply_byte(i, dbuf[i]);
      end
    end
    bus_stop();
  endtask

  initial begin
    logic ack;
    void'($urandom(32'd4242));
    wait_cyc(8);
    rst = 1'b0;
    wait_cyc(3);

    // R1 reset state
    check("R1 sda released", {31'd0, sda_oe}, 32'd0);
    check_outputs("R1 reset outputs");

    // R4 R5 R6 directed write
    for (int i = 0; i < 8; i++) dbuf[i] = 8'h3C;
    dbuf[6] = 8'b1110_0101;
    dbuf[7] = 8'hA5;
    block_write(7'h69, 1'b0, 8, 1'b1, "directed");
    check_outputs("R4 R5 R6 R8 mapping mode1");
    mode_inv = 1'b0;
    check_outputs("R8 R9 mapping mode0");
    mode_inv = 1'b1;

    // R7 power down
    pwrdn_n = 1'b0;
    check_outputs("R7 power down");
    pwrdn_n = 1'b1;
    check_outputs("R7 power restored");

    // R2 wrong address and read bit
    dbuf[6] = 8'h1F; dbuf[7] = 8'hFF;
    block_write(7'h6A, 1'b0, 8, 1'b0, "wrong addr");
    check_outputs("R2 wrong address no effect");
    block_write(7'h69, 1'b1, 8, 1'b0, "read bit");
    check_outputs("R2 read bit no effect");

    // R10 partial byte before stop
    bus_start();
    send_byte({7'h69, 1'b0}, -1, ack);
    send_byte(8'h00, -1, ack);
    send_byte(8'd8, -1, ack);
    for (int i = 0; i < 6; i++) send_byte(8'h00, -1, ack);
    send_byte(8'h13, -1, ack);
    apply_byte(6, 8'h13);
    for (int i = 7; i >= 3; i--) send_bit(1'b0, 1'b0);
    bus_stop();
    check_outputs("R10 partial byte discarded");

    // R10 repeated start mid byte, then new full transfer
    bus_start();
    send_byte({7'h69, 1'b0}, -1, ack);
    send_byte(8'h00, -1, ack);
    send_byte(8'd8, -1, ack);
    for (int i = 0; i < 7; i++) send_byte(8'h0A, -1, ack);
    apply_byte(6, 8'h0A);
    for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0);
    dbuf[6] = 8'h1C; dbuf[7] = 8'h5A;
    for (int i = 0; i < 6; i++) dbuf[i] = 8'hFF;
    block_write(7'h69, 1'b0, 8, 1'b1, "repeated start");
    check_outputs("R10 repeated start");

    // R11 short SCL pulse ignored
    bus_start();
    send_byte({7'h69, 1'b0}, -1, ack);
    send_byte(8'h00, -1, ack);
    send_byte(8'd8, -1, ack);
    for (int i = 0; i < 7; i++) send_byte(8'h17, -1, ack);
    apply_byte(6, 8'h17);
    send_byte(8'hC3, 4, ack);
    check("R11 glitched byte ack", {31'd0, ack}, 32'd1);
    apply_byte(7, 8'hC3);
    bus_stop();
    check_outputs("R11 glitch rejected");

    // R3 short block touches only index 6
    dbuf[6] = 8'h05;
    block_write(7'h69, 1'b0, 7, 1'b1, "short block");
    check_outputs("R3 short block");

    // random transfers
    for (int it = 0; it < 14; it++) begin
      logic [6:0] a;
      int n;
      a = ($urandom % 5 == 0) ? 7'($urandom) : 7'h69;
      n = $urandom % 11;
      for (int i = 0; i < 16; i++) dbuf[i] = 8'($urandom);
      block_write(a, 1'b0, n, a == 7'h69, "random");
      mode_inv = 1'($urandom);
      pwrdn_n = ($urandom % 6) != 0;
      check_outputs("R3 R6 R7 R8 R9 random");
      pwrdn_n = 1'b1;
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4.0 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule